// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

A small, fully associative translation buffer whose entries carry the address-space identifier that was current when they were filled. A lookup presents a virtual page number and receives, in the same cycle, a hit flag, the physical page number, the permission bits and a fault flag. A lookup is a hit only when an entry has both the same page number and the same identifier as the current one. The fault flag is formed per entry, in parallel with the match, so it never waits on the combined hit result.

A lookup that misses starts a page-walk request toward an external walker. The request is held until the walker accepts it. The block then tracks it as in flight until the walker responds, and the response fills an entry tagged with the identifier current at that moment. When the current identifier changes, every pending and in-flight request is dropped, but the stored translations stay valid. A flush command empties the whole buffer whatever identifier operand it carries. It also drops all walks. Refills prefer an empty entry and otherwise evict by tree pseudo-LRU.

Top module: `asid_tlb`

## Requirements
- R1: After reset no lookup hits, the fault flag is 0 and no walk request is raised.
- R2: A valid lookup hits only if a valid entry matches both `lkp_vpn` and `cur_asid`. On a hit, `lkp_ppn` and `lkp_perm` show that entry in the same cycle.
- R3: A valid lookup that misses raises `walk_req_valid` with that page number in the next cycle. The request stays asserted with a stable page number until `walk_req_ready` is seen, unless it is cancelled.
- R4: While a walk for a page number is pending or in flight, further misses to that page number start no second request.
- R5: A walk response whose page number matches an in-flight request fills an entry tagged with the current identifier. The entry hits from the next cycle on.
- R6: Two identifiers can map the same page number to different physical pages, and each reads back its own mapping.
- R7: A flush clears every entry whatever value `flush_asid` has. It also drops pending and in-flight walks, so a later response for them does not fill.
- R8: A change of `cur_asid` drops the pending request and all in-flight walks, so their responses do not fill. Entries already stored stay valid and hit again when their identifier returns.
- R9: `lkp_fault` is 1 only on a hit whose permission lacks the needed right. Access code 0 needs read (perm bit 0), code 1 needs write (bit 1), code 2 needs execute (bit 2), and code 3 always faults. On a miss the fault flag is 0.
- R10: A refill goes to the lowest-numbered empty entry. When all entries are full, it goes to the tree pseudo-LRU victim, which is updated by hits and refills.
- R11: A walk response whose page number is not in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_asid | input | ASID_W (16) | Current address-space identifier |
| lkp_valid | input | 1 | Lookup request |
| lkp_vpn | input | VPN_W (20) | Lookup virtual page number |
| lkp_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| lkp_hit | output | 1 | Lookup hit |
| lkp_ppn | output | PPN_W (20) | Translated physical page number |
| lkp_perm | output | 3 | Permission bits of the hit entry (read, write, execute) |
| lkp_fault | output | 1 | Permission fault on the hit entry |
| flush_valid | input | 1 | Flush every entry |
| flush_asid | input | ASID_W (16) | Identifier operand of the flush, ignored |
| walk_req_valid | output | 1 | Walk request to the page walker |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_vpn | output | VPN_W (20) | Page number to walk |
| walk_resp_valid | input | 1 | Walker response |
| walk_resp_vpn | input | VPN_W (20) | Page number of the response |
| walk_resp_ppn | input | PPN_W (20) | Physical page number from the walker |
| walk_resp_perm | input | 3 | Permission bits from the walker |

## Verification
A wrong identifier tag or a stale valid bit shows up at the ports on the first lookup to that page. It appears either as a hit with the other space's physical page or as a miss where a hit is expected. A tracker that fails to drop a cancelled walk shows up the cycle after the late response, as a hit on a page that should have missed. A bad replacement choice appears only once all entries are full: the wrong page misses on the lookups that follow the refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W     = 20;
    parameter int PPN_W     = 20;
    parameter int ASID_W    = 16;
    localparam int PERM_BITS = 3;
    localparam int P_READ    = 0;
    localparam int P_WRITE   = 1;
    localparam int P_EXEC    = 2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic                  valid;
        logic [ASID_W-1:0]     asid;
        logic [VPN_W-1:0]      vpn;
        logic [PPN_W-1:0]      ppn;
        logic [PERM_BITS-1:0]  perm;
    } tlb_entry_t;

    function automatic logic perm_denied(logic [PERM_BITS-1:0] perm, acc_e acc);
        case (acc)
            ACC_LOAD:  return !perm[P_READ];
            ACC_STORE: return !perm[P_WRITE];
            ACC_FETCH: return !perm[P_EXEC];
            default:   return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/tlb_plru.sv
module tlb_plru #(
    parameter int N = 8,
    localparam int L = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         touch_en,
    input  logic [L-1:0] touch_way,
    output logic [L-1:0] victim_way
);
    // node k (1-based heap index) lives at tree_q[k-1]; 0 = left side is older
    logic [N-2:0] tree_q, tree_d;

    always_comb begin
        int idx;
        idx = 1;
        for (int lvl = 0; lvl < L; lvl++) begin
            idx = 2 * idx + int'(tree_q[idx-1]);
        end
        victim_way = L'(idx - N);
    end

    always_comb begin
        int idx;
        logic b;
        tree_d = tree_q;
        idx = 1;
        for (int lvl = 0; lvl < L; lvl++) begin
            b = touch_way[L-1-lvl];
            tree_d[idx-1] = ~b;
            idx = 2 * idx + int'(b);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           tree_q <= '0;
        else if (touch_en) tree_q <= tree_d;
    end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam import tlb_pkg::*; #(
    parameter int N = 8,
    localparam int WAY_W = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lkp_valid,
    input  logic [VPN_W-1:0]      lkp_vpn,
    input  logic [ASID_W-1:0]     cur_asid,
    input  acc_e                  acc,
    output logic [N-1:0]          hit_vec,
    output logic                  hit,
    output logic [PPN_W-1:0]      ppn,
    output logic [PERM_BITS-1:0]  perm,
    output logic                  fault,
    output logic [N-1:0]          valid_vec,
    input  logic                  flush,
    input  logic                  wr_en,
    input  logic [WAY_W-1:0]      wr_way,
    input  tlb_entry_t            wr_entry
);
    tlb_entry_t ent_q [N];
    logic [N-1:0] deny_vec;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic tag_eq;
        assign tag_eq       = ent_q[g].valid && (ent_q[g].vpn == lkp_vpn)
                              && (ent_q[g].asid == cur_asid);
        assign hit_vec[g]   = lkp_valid && tag_eq;
        // per-entry fault term, formed beside the match rather than after it
        assign deny_vec[g]  = lkp_valid && tag_eq && perm_denied(ent_q[g].perm, acc);
        assign valid_vec[g] = ent_q[g].valid;
    end

    always_comb begin
        ppn  = '0;
        perm = '0;
        for (int i = 0; i < N; i++) begin
            ppn  = ppn  | (ent_q[i].ppn  & {PPN_W{hit_vec[i]}});
            perm = perm | (ent_q[i].perm & {PERM_BITS{hit_vec[i]}});
        end
    end

    assign hit   = |hit_vec;
    assign fault = |deny_vec;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N; i++) ent_q[i].valid <= 1'b0;
        end else if (wr_en) begin
            ent_q[wr_way] <= wr_entry;
        end
    end
endmodule

// File: rtl/tlb_walk_track.sv
module tlb_walk_track import tlb_pkg::*; #(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cancel,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [VPN_W-1:0]  req_vpn,
    input  logic              resp_valid,
    input  logic [VPN_W-1:0]  resp_vpn,
    output logic              refill_en
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              pend_q;
    logic [VPN_W-1:0]  pend_vpn_q;
    logic [DEPTH-1:0]  slot_v_q;
    logic [VPN_W-1:0]  slot_vpn_q [DEPTH];

    logic [DEPTH-1:0]  slot_miss_eq, slot_resp_eq;
    logic              has_free;
    logic [IDX_W-1:0]  free_idx;
    logic              capture, accept;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_miss_eq[g] = slot_v_q[g] && (slot_vpn_q[g] == miss_vpn);
        assign slot_resp_eq[g] = slot_v_q[g] && (slot_vpn_q[g] == resp_vpn);
    end

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_v_q[i]) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign capture = miss_valid && !cancel && !pend_q && !(|slot_miss_eq) && has_free
                     && !(resp_valid && (resp_vpn == miss_vpn));
    assign accept    = pend_q && req_ready;
    assign refill_en = resp_valid && (|slot_resp_eq) && !cancel;
    assign req_valid = pend_q;
    assign req_vpn   = pend_vpn_q;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            pend_q   <= 1'b0;
            slot_v_q <= '0;
        end else begin
            if (accept) begin
                pend_q               <= 1'b0;
                slot_v_q[free_idx]   <= 1'b1;
                slot_vpn_q[free_idx] <= pend_vpn_q;
            end
            if (capture) begin
                pend_q     <= 1'b1;
                pend_vpn_q <= miss_vpn;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (resp_valid && slot_resp_eq[i]) slot_v_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb import tlb_pkg::*; #(
    parameter int N_ENTRIES = 8,
    parameter int N_WALKS   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ASID_W-1:0]     cur_asid,
    input  logic                  lkp_valid,
    input  logic [VPN_W-1:0]      lkp_vpn,
    input  logic [1:0]            lkp_acc,
    output logic                  lkp_hit,
    output logic [PPN_W-1:0]      lkp_ppn,
    output logic [PERM_BITS-1:0]  lkp_perm,
    output logic                  lkp_fault,
    input  logic                  flush_valid,
    input  logic [ASID_W-1:0]     flush_asid,
    output logic                  walk_req_valid,
    input  logic                  walk_req_ready,
    output logic [VPN_W-1:0]      walk_req_vpn,
    input  logic                  walk_resp_valid,
    input  logic [VPN_W-1:0]      walk_resp_vpn,
    input  logic [PPN_W-1:0]      walk_resp_ppn,
    input  logic [PERM_BITS-1:0]  walk_resp_perm
);
    localparam int WAY_W = $clog2(N_ENTRIES);

    logic [ASID_W-1:0]    asid_q;
    logic                 asid_chg, cancel;
    logic [N_ENTRIES-1:0] hit_vec, valid_vec;
    logic                 refill_en;
    logic [WAY_W-1:0]     plru_victim, victim_way, hit_way, touch_way;
    tlb_entry_t           new_entry;

    assign asid_chg = (cur_asid != asid_q);
    assign cancel   = flush_valid || asid_chg;

    always_ff @(posedge clk) begin
        if (rst) asid_q <= '0;
        else     asid_q <= cur_asid;
    end

    always_comb begin
        victim_way = plru_victim;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) victim_way = WAY_W'(i);
        end
    end

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (hit_vec[i]) hit_way = WAY_W'(i);
        end
    end

    assign touch_way = refill_en ? victim_way : hit_way;

    always_comb begin
        new_entry.valid = 1'b1;
        new_entry.asid  = cur_asid;
        new_entry.vpn   = walk_resp_vpn;
        new_entry.ppn   = walk_resp_ppn;
        new_entry.perm  = walk_resp_perm;
    end

    tlb_cam #(.N(N_ENTRIES)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .lkp_valid (lkp_valid),
        .lkp_vpn   (lkp_vpn),
        .cur_asid  (cur_asid),
        .acc       (acc_e'(lkp_acc)),
        .hit_vec   (hit_vec),
        .hit       (lkp_hit),
        .ppn       (lkp_ppn),
        .perm      (lkp_perm),
        .fault     (lkp_fault),
        .valid_vec (valid_vec),
        .flush     (flush_valid),
        .wr_en     (refill_en && !flush_valid),
        .wr_way    (victim_way),
        .wr_entry  (new_entry)
    );

    tlb_plru #(.N(N_ENTRIES)) u_plru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (refill_en || lkp_hit),
        .touch_way  (touch_way),
        .victim_way (plru_victim)
    );

    tlb_walk_track #(.DEPTH(N_WALKS)) u_track (
        .clk        (clk),
        .rst        (rst),
        .cancel     (cancel),
        .miss_valid (lkp_valid && !lkp_hit),
        .miss_vpn   (lkp_vpn),
        .req_valid  (walk_req_valid),
        .req_ready  (walk_req_ready),
        .req_vpn    (walk_req_vpn),
        .resp_valid (walk_resp_valid),
        .resp_vpn   (walk_resp_vpn),
        .refill_en  (refill_en)
    );
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk import tlb_pkg::*; #(
    parameter int N_ENTRIES = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [ASID_W-1:0]     cur_asid,
    input logic                  asid_chg,
    input logic                  flush_valid,
    input logic [ASID_W-1:0]     flush_asid,
    input logic                  lkp_hit,
    input logic                  lkp_fault,
    input logic [N_ENTRIES-1:0]  hit_vec,
    input logic                  walk_req_valid,
    input logic                  walk_req_ready,
    input logic [VPN_W-1:0]      walk_req_vpn
);
    // R2: identifier-qualified match never selects two entries
    a_r2_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R3: an unaccepted request is held with a stable page number
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (walk_req_valid && !walk_req_ready && !flush_valid && !asid_chg)
        |=> (walk_req_valid && $stable(walk_req_vpn)));

    // R7: flush with any operand leaves nothing to hit
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_valid |=> !lkp_hit);

    // R7: operand differing from the current identifier still empties
    a_r7_operand_ignored: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && (flush_asid != cur_asid)) |=> !lkp_hit);

    // R8: identifier change drops the pending request
    a_r8_switch_drops_req: assert property (@(posedge clk) disable iff (rst)
        asid_chg |=> !walk_req_valid);

    // R9: a fault only accompanies a hit
    a_r9_fault_needs_hit: assert property (@(posedge clk) disable iff (rst)
        lkp_fault |-> lkp_hit);
endmodule

bind asid_tlb asid_tlb_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cur_asid       (cur_asid),
    .asid_chg       (asid_chg),
    .flush_valid    (flush_valid),
    .flush_asid     (flush_asid),
    .lkp_hit        (lkp_hit),
    .lkp_fault      (lkp_fault),
    .hit_vec        (hit_vec),
    .walk_req_valid (walk_req_valid),
    .walk_req_ready (walk_req_ready),
    .walk_req_vpn   (walk_req_vpn)
);

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
    import tlb_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [ASID_W-1:0]    cur_asid = 16'd1;
    logic                 lkp_valid = 1'b0;
    logic [VPN_W-1:0]     lkp_vpn = '0;
    logic [1:0]           lkp_acc = 2'd0;
    logic                 lkp_hit, lkp_fault;
    logic [PPN_W-1:0]     lkp_ppn;
    logic [PERM_BITS-1:0] lkp_perm;
    logic                 flush_valid = 1'b0;
    logic [ASID_W-1:0]    flush_asid = '0;
    logic                 walk_req_valid;
    logic                 walk_req_ready = 1'b0;
    logic [VPN_W-1:0]     walk_req_vpn;
    logic                 walk_resp_valid = 1'b0;
    logic [VPN_W-1:0]     walk_resp_vpn = '0;
    logic [PPN_W-1:0]     walk_resp_ppn = '0;
    logic [PERM_BITS-1:0] walk_resp_perm = '0;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    asid_tlb dut_i (
        .clk(clk), .rst(rst), .cur_asid(cur_asid),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_acc(lkp_acc),
        .lkp_hit(lkp_hit), .lkp_ppn(lkp_ppn), .lkp_perm(lkp_perm), .lkp_fault(lkp_fault),
        .flush_valid(flush_valid), .flush_asid(flush_asid),
        .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
        .walk_req_vpn(walk_req_vpn), .walk_resp_valid(walk_resp_valid),
        .walk_resp_vpn(walk_resp_vpn), .walk_resp_ppn(walk_resp_ppn),
        .walk_resp_perm(walk_resp_perm)
    );

    typedef struct packed {
        logic [15:0] asid;
        logic [19:0] vpn;
        logic [1:0]  acc;
        logic        hit;
        logic [19:0] ppn;
        logic        fault;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'd1, 20'h123, 2'd0, 1'b1, 20'hAAA, 1'b0},
        '{16'd2, 20'h123, 2'd0, 1'b1, 20'hBBB, 1'b0},
        '{16'd1, 20'h123, 2'd2, 1'b1, 20'hAAA, 1'b1},
        '{16'd2, 20'h123, 2'd2, 1'b1, 20'hBBB, 1'b0},
        '{16'd2, 20'h055, 2'd0, 1'b0, 20'h000, 1'b0},
        '{16'd1, 20'h055, 2'd1, 1'b1, 20'h501, 1'b1},
        '{16'd1, 20'h056, 2'd0, 1'b0, 20'h000, 1'b0},
        '{16'd3, 20'h123, 2'd0, 1'b0, 20'h000, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_map(input logic [19:0] vpn, input logic [19:0] ppn, input logic [2:0] perm);
        @(negedge clk); lkp_valid = 1'b1; lkp_vpn = vpn; lkp_acc = 2'd0;
        @(negedge clk); lkp_valid = 1'b0; walk_req_ready = 1'b1;
        @(negedge clk); walk_req_ready = 1'b0; walk_resp_valid = 1'b1;
        walk_resp_vpn = vpn; walk_resp_ppn = ppn; walk_resp_perm = perm;
        @(negedge clk); walk_resp_valid = 1'b0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic [1:0] acc);
        @(negedge clk); lkp_valid = 1'b1; lkp_vpn = vpn; lkp_acc = acc; #1;
    endtask

    task automatic idle();
        @(negedge clk); lkp_valid = 1'b0;
    endtask

    task automatic drop_pending();
        logic [15:0] keep;
        keep = cur_asid;
        @(negedge clk); lkp_valid = 1'b0; cur_asid = 16'hFFFF;
        @(negedge clk); cur_asid = keep;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(4 * 100000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R3 request raised and held
        look(20'h40, 2'd0);
        check("R1", "hit after reset", lkp_hit, 0);
        check("R1", "fault after reset", lkp_fault, 0);
        check("R1", "no request after reset", walk_req_valid, 0);
        look(20'h40, 2'd0);
        check("R3", "request raised", walk_req_valid, 1);
        check("R3", "request vpn", walk_req_vpn, 20'h40);
        idle(); #1;
        check("R3", "request held", walk_req_valid, 1);
        walk_req_ready = 1'b1;
        @(negedge clk); walk_req_ready = 1'b0;
        lkp_valid = 1'b1; lkp_vpn = 20'h40;
        @(negedge clk); lkp_valid = 1'b0; #1;
        check("R4", "no duplicate walk", walk_req_valid, 0);
        walk_resp_valid = 1'b1; walk_resp_vpn = 20'h40;
        walk_resp_ppn = 20'h440; walk_resp_perm = 3'b111;
        @(negedge clk); walk_resp_valid = 1'b0;
        lkp_valid = 1'b1; lkp_vpn = 20'h40; #1;
        check("R5", "refill hit", lkp_hit, 1);
        check("R5", "refill ppn", lkp_ppn, 20'h440);
        check("R5", "refill perm", lkp_perm, 3'b111);
        idle();

        // R11 unsolicited response
        @(negedge clk); walk_resp_valid = 1'b1; walk_resp_vpn = 20'h777; walk_resp_ppn = 20'h1;
        @(negedge clk); walk_resp_valid = 1'b0;
        look(20'h777, 2'd0);
        check("R11", "unsolicited not filled", lkp_hit, 0);
        drop_pending();

        // R8 in-flight walk dropped, entries kept
        look(20'h300, 2'd0);
        @(negedge clk); lkp_valid = 1'b0; walk_req_ready = 1'b1;
        @(negedge clk); walk_req_ready = 1'b0; cur_asid = 16'd3;
        @(negedge clk); walk_resp_valid = 1'b1; walk_resp_vpn = 20'h300; walk_resp_ppn = 20'h999;
        @(negedge clk); walk_resp_valid = 1'b0; cur_asid = 16'd1;
        @(negedge clk);
        look(20'h300, 2'd0);
        check("R8", "cancelled walk not filled", lkp_hit, 0);
        look(20'h40, 2'd0);
        check("R8", "stored entry kept", lkp_hit, 1);
        check("R8", "stored ppn kept", lkp_ppn, 20'h440);
        drop_pending();
        look(20'h301, 2'd0);
        @(negedge clk); lkp_valid = 1'b0; #1;
        check("R3", "second request raised", walk_req_valid, 1);
        cur_asid = 16'd3;
        @(negedge clk); #1;
        check("R8", "pending dropped", walk_req_valid, 0);
        cur_asid = 16'd1;
        @(negedge clk);

        // R2, R6, R9 vector table
        do_map(20'h123, 20'hAAA, 3'b011);
        do_map(20'h055, 20'h501, 3'b001);
        @(negedge clk); cur_asid = 16'd2;
        @(negedge clk);
        do_map(20'h123, 20'hBBB, 3'b111);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cur_asid = VECS[i].asid; lkp_valid = 1'b1;
            lkp_vpn = VECS[i].vpn; lkp_acc = VECS[i].acc; #1;
            check("R2/R6", $sformatf("vector %0d hit", i), lkp_hit, VECS[i].hit);
            if (VECS[i].hit)
                check("R6", $sformatf("vector %0d ppn", i), lkp_ppn, VECS[i].ppn);
            check("R9", $sformatf("vector %0d fault", i), lkp_fault, VECS[i].fault);
        end
        idle(); cur_asid = 16'd1;
        drop_pending();

        // R7 flush with foreign operand drops entries and in-flight walk
        look(20'h500, 2'd0);
        @(negedge clk); lkp_valid = 1'b0; walk_req_ready = 1'b1;
        @(negedge clk); walk_req_ready = 1'b0; flush_valid = 1'b1; flush_asid = 16'h9;
        @(negedge clk); flush_valid = 1'b0;
        walk_resp_valid = 1'b1; walk_resp_vpn = 20'h500; walk_resp_ppn = 20'h5;
        @(negedge clk); walk_resp_valid = 1'b0;
        look(20'h500, 2'd0);
        check("R7", "in-flight after flush", lkp_hit, 0);
        look(20'h123, 2'd0);
        check("R7", "entry of current space flushed", lkp_hit, 0);
        idle(); cur_asid = 16'd2;
        look(20'h123, 2'd0);
        check("R7", "entry of other space flushed", lkp_hit, 0);
        idle(); cur_asid = 16'd1;
        drop_pending();

        // R10 fill order and pseudo-LRU victim
        for (int k = 0; k < 8; k++) do_map(20'h10 + 20'(k), 20'h100 + 20'(k), 3'b001);
        look(20'h10, 2'd0);
        check("R10", "touch way 0", lkp_hit, 1);
        idle();
        do_map(20'h20, 20'h200, 3'b001);
        look(20'h20, 2'd0);
        check("R10", "new page resident", lkp_hit, 1);
        check("R10", "new page ppn", lkp_ppn, 20'h200);
        for (int k = 0; k < 8; k++) begin
            look(20'h10 + 20'(k), 2'd0);
            check("R10", $sformatf("page 0x%0h resident", 16 + k), lkp_hit, (k == 4) ? 0 : 1);
            if (k != 4)
                check("R10", $sformatf("page 0x%0h ppn", 16 + k), lkp_ppn, 20'h100 + 20'(k));
        end
        idle();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule